// File: doc/BRIEF.md
# 5B Symbol Aligner and Frame Decoder

This block sits behind a descrambler on the receive side of a 100 Mb/s twisted-pair physical layer. It takes a serial bit stream that is already descrambled but has no known 5-bit code-group boundary. Each bit arrives with a qualifier and a lock indication. While hunting, the block looks for the start-of-stream delimiter, an idle group followed by the J and K groups. That match fixes the code-group boundary. From then on, every five accepted bits form one group, and each group is translated to a 4-bit nibble.

The J and K groups come out as two preamble nibbles. Data groups come out as their 4-bit values, each with a one-cycle nibble strobe, while a receive-valid level marks the frame. A T group followed by an R group ends the frame. A mid-frame idle, or loss of lock, also ends it. A group that is not a data code raises a receive-error flag on its nibble.

The control is a four-state machine. HUNT searches for the delimiter. PRE_K emits the second preamble nibble. FRAME decodes data groups. WAIT_R checks the group that follows T. The transitions are:
- HUNT to PRE_K on a delimiter match.
- PRE_K to FRAME unconditionally.
- FRAME to WAIT_R on T.
- FRAME to HUNT on idle.
- WAIT_R to HUNT on the next group.
- Any state to HUNT when lock is low.

Top module: `sym_frame_rx`

## Requirements
- R1: While reset is asserted, and after its release until a delimiter is found, rxd is 0000 and rx_dv, rx_er and nib_stb are 0.
- R2: A start-of-stream is detected when the last 15 accepted bits are 11111 11000 10001 (idle, J, K), where the earliest bit received is the leftmost bit of each group. Detection works at any bit offset. Later groups are taken every 5 accepted bits from the end of that pattern.
- R3: If J and K are not immediately preceded by 11111, no frame is started: there is no nib_stb and rx_dv stays 0.
- R4: On detection, nib_stb pulses on two consecutive cycles with rxd = 0101, and rx_dv rises together with the first of those pulses.
- R5: In FRAME, each data group produces one nib_stb with rxd equal to its nibble, rxd[0] being the least significant bit. The data codes are:
  - 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111
  - 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101
- R6: The group T (01101) ends the frame. rx_dv falls at the edge that accepts the last T bit, and no strobe is issued. If the next group is R (00111), nothing further happens. If it is any other group, rx_er pulses for one cycle without nib_stb.
- R7: In FRAME, a group that is none of the data codes, idle, T or R gives a nib_stb with rx_er = 1 and rxd = 0000. rx_dv stays 1 and decoding continues.
- R8: An R group in FRAME that is not preceded by T produces no strobe and no error, and the frame continues.
- R9: An idle group (11111) in FRAME ends the frame. rx_dv falls, and no further nibbles are issued until a new delimiter is found.
- R10: When rx_lock is 0 at a clock edge, rx_dv is 0 after that edge, partial alignment is discarded, and the block returns to HUNT.
- R11: A cycle with rx_bit_vld = 0 accepts no bit and does not disturb alignment or decoding.
- R12: nib_stb is never 1 while rx_dv is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Descrambled serial bit |
| rx_bit_vld | input | 1 | rx_bit is valid this cycle |
| rx_lock | input | 1 | Descrambler lock indication |
| rxd | output | 4 | Decoded nibble, bit 0 least significant |
| rx_dv | output | 1 | Receive data valid, high for the frame |
| rx_er | output | 1 | Receive error pulse |
| nib_stb | output | 1 | One-cycle strobe per delivered nibble |

## Verification
The bench places the delimiter at a bit offset that is not a multiple of five. A design that assumed fixed framing from reset would then decode garbage nibbles. It sends J and K with no idle in front, which a matcher that ignores the idle prefix would wrongly accept as a frame. It also injects an invalid code, a lone R, a mid-frame idle, a lock drop and a T followed by a non-R group. These catch, respectively:
- an error flag raised on the wrong nibble, or a frame aborted on an invalid code;
- a spurious strobe for R;
- rx_dv held after an abort;
- a missing error pulse after T.

Gapped bit qualifiers check that the group counter advances only on accepted bits.

// File: rtl/symalign_pkg.sv
package symalign_pkg;
    localparam int GRP_W = 5;
    localparam int NIB_W = 4;
    localparam int WIN_W = 3 * GRP_W;

    localparam logic [GRP_W-1:0] SYM_IDLE = 5'b11111;
    localparam logic [GRP_W-1:0] SYM_J    = 5'b11000;
    localparam logic [GRP_W-1:0] SYM_K    = 5'b10001;
    localparam logic [GRP_W-1:0] SYM_T    = 5'b01101;
    localparam logic [GRP_W-1:0] SYM_R    = 5'b00111;

    localparam logic [NIB_W-1:0] PREAMBLE_NIB = 4'b0101;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PRE_K,
        ST_FRAME,
        ST_WAIT_R
    } fsm_t;
endpackage

// File: rtl/sym_shifter.sv
module sym_shifter
    import symalign_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             bit_vld,
    input  logic             lock,
    input  logic             hunt,
    output logic             grp_done,
    output logic [GRP_W-1:0] grp,
    output logic             ssd_hit
);
    localparam int CW = $clog2(GRP_W);
    localparam logic [WIN_W-1:0] SSD_PAT = {SYM_IDLE, SYM_J, SYM_K};

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_n;
    logic [CW-1:0]    cnt_q;
    logic             take;

    assign take     = bit_vld & lock;
    assign win_n    = {win_q[WIN_W-2:0], rx_bit};
    assign ssd_hit  = hunt & take & (win_n == SSD_PAT);
    assign grp_done = take & (cnt_q == CW'(GRP_W - 1));
    assign grp      = win_n[GRP_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (!lock) begin
            win_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            win_q <= win_n;
            if (ssd_hit || grp_done) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sym_decode.sv
module sym_decode
    import symalign_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    output logic             is_data,
    output logic [NIB_W-1:0] nib,
    output logic             is_idle,
    output logic             is_t,
    output logic             is_r
);
    assign is_idle = (grp == SYM_IDLE);
    assign is_t    = (grp == SYM_T);
    assign is_r    = (grp == SYM_R);

    always_comb begin
        is_data = 1'b1;
        nib     = '0;
        unique case (grp)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            default:  is_data = 1'b0;
        endcase
    end
endmodule

// File: rtl/sym_frame_rx.sv
module sym_frame_rx
    import symalign_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_bit_vld,
    input  logic             rx_lock,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             nib_stb
);
    fsm_t             state_q, state_n;
    logic             grp_done, ssd_hit;
    logic [GRP_W-1:0] grp;
    logic             is_data, is_idle, is_t, is_r;
    logic [NIB_W-1:0] dec_nib;
    logic [NIB_W-1:0] rxd_n;
    logic             dv_n, er_n, stb_n;

    sym_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_bit   (rx_bit),
        .bit_vld  (rx_bit_vld),
        .lock     (rx_lock),
        .hunt     (state_q == ST_HUNT),
        .grp_done (grp_done),
        .grp      (grp),
        .ssd_hit  (ssd_hit)
    );

    sym_decode u_dec (
        .grp     (grp),
        .is_data (is_data),
        .nib     (dec_nib),
        .is_idle (is_idle),
        .is_t    (is_t),
        .is_r    (is_r)
    );

    always_comb begin
        state_n = state_q;
        rxd_n   = rxd;
        dv_n    = rx_dv;
        er_n    = 1'b0;
        stb_n   = 1'b0;
        if (!rx_lock) begin
            state_n = ST_HUNT;
            dv_n    = 1'b0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (ssd_hit) begin
                        state_n = ST_PRE_K;
                        rxd_n   = PREAMBLE_NIB;
                        dv_n    = 1'b1;
                        stb_n   = 1'b1;
                    end
                end
                ST_PRE_K: begin
                    state_n = ST_FRAME;
                    rxd_n   = PREAMBLE_NIB;
                    stb_n   = 1'b1;
                end
                ST_FRAME: begin
                    if (grp_done) begin
                        if (is_t) begin
                            state_n = ST_WAIT_R;
                            dv_n    = 1'b0;
                        end else if (is_idle) begin
                            state_n = ST_HUNT;
                            dv_n    = 1'b0;
                        end else if (is_data) begin
                            rxd_n = dec_nib;
                            stb_n = 1'b1;
                        end else if (!is_r) begin
                            rxd_n = '0;
                            er_n  = 1'b1;
                            stb_n = 1'b1;
                        end
                    end
                end
                ST_WAIT_R: begin
                    if (grp_done) begin
                        state_n = ST_HUNT;
                        er_n    = !is_r;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd     <= '0;
            rx_dv   <= 1'b0;
            rx_er   <= 1'b0;
            nib_stb <= 1'b0;
        end else begin
            rxd     <= rxd_n;
            rx_dv   <= dv_n;
            rx_er   <= er_n;
            nib_stb <= stb_n;
        end
    end
endmodule

// File: rtl/sym_frame_rx_chk.sv
module sym_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_lock,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       rx_er,
    input logic       nib_stb
);
    AST_STB_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |-> rx_dv); // R12

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_lock |=> !rx_dv); // R10

    AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> (nib_stb && rxd == 4'b0101)); // R4

    AST_PRE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |=> (nib_stb && rxd == 4'b0101)); // R4

    AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_er && rx_dv) |-> (nib_stb && rxd == 4'b0000)); // R7
endmodule

bind sym_frame_rx sym_frame_rx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_lock (rx_lock),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .nib_stb (nib_stb)
);

// File: tb/sym_frame_rx_tb.sv
module sym_frame_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_bit_vld = 1'b0;
    logic       rx_lock = 1'b0;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, nib_stb;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [3:0] cap_nib [32];
    logic       cap_er  [32];
    int         cap_n, er_alone, stb_no_dv;
    logic [3:0] exp_nib [32];
    logic       exp_er  [32];
    int         exp_n;

    localparam logic [4:0] G_IDLE = 5'b11111;
    localparam logic [4:0] G_J    = 5'b11000;
    localparam logic [4:0] G_K    = 5'b10001;
    localparam logic [4:0] G_T    = 5'b01101;
    localparam logic [4:0] G_R    = 5'b00111;

    always #10 clk = ~clk;

    sym_frame_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_bit_vld (rx_bit_vld),
        .rx_lock    (rx_lock),
        .rxd        (rxd),
        .rx_dv      (rx_dv),
        .rx_er      (rx_er),
        .nib_stb    (nib_stb)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (nib_stb) begin
                if (cap_n < 32) begin
                    cap_nib[cap_n] = rxd;
                    cap_er[cap_n]  = rx_er;
                end
                cap_n = cap_n + 1;
                if (!rx_dv) stb_no_dv = stb_no_dv + 1;
            end else if (rx_er) begin
                er_alone = er_alone + 1;
            end
        end
    end

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
            4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
            4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
            4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
            4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; er_alone = 0; stb_no_dv = 0; exp_n = 0;
    endtask

    task automatic push_exp(input logic [3:0] n, input logic e);
        exp_nib[exp_n] = n;
        exp_er[exp_n]  = e;
        exp_n++;
    endtask

    task automatic send_grp(input logic [4:0] g, input bit gap);
        for (int i = 4; i >= 0; i--) begin
            rx_bit = g[i];
            rx_bit_vld = 1'b1;
            @(negedge clk);
            if (gap) begin
                rx_bit = ~g[i];
                rx_bit_vld = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
        end
        rx_bit_vld = 1'b0;
    endtask

    task automatic send_nib(input logic [3:0] n);
        send_grp(enc(n), 1'b0);
    endtask

    task automatic send_ssd();
        send_grp(G_IDLE, 1'b0);
        send_grp(G_IDLE, 1'b0);
        send_grp(G_J, 1'b0);
        send_grp(G_K, 1'b0);
    endtask

    task automatic compare(input string req, input int exp_er_alone);
        chk(cap_n == exp_n, {req, " nibble count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_nib[i] == exp_nib[i], {req, " nibble value"}, cap_nib[i], exp_nib[i]);
            chk(cap_er[i] == exp_er[i], {req, " nibble error flag"}, cap_er[i], exp_er[i]);
        end
        chk(stb_no_dv == 0, "R12 strobe without rx_dv", stb_no_dv, 0);
        chk(er_alone == exp_er_alone, {req, " lone error pulses"}, er_alone, exp_er_alone);
    endtask

    // R1
    task automatic t_reset();
        rst_n = 1'b0; rx_lock = 1'b0;
        repeat (3) @(negedge clk);
        chk(rxd == 4'h0 && !rx_dv && !rx_er && !nib_stb, "R1 outputs in reset",
            {rxd, rx_dv, rx_er, nib_stb}, 0);
        rst_n = 1'b1; rx_lock = 1'b1;
        clear_cap();
        repeat (3) @(negedge clk);
        chk(rxd == 4'h0 && !rx_dv && !rx_er && !nib_stb, "R1 outputs after reset",
            {rxd, rx_dv, rx_er, nib_stb}, 0);
    endtask

    // R2 R4 R5 R6: plain frame, rxd[0] LSB shown by 1 versus 8
    task automatic t_basic();
        clear_cap();
        send_grp(G_IDLE, 1'b0);
        send_ssd();
        chk(rx_dv == 1'b1, "R4 rx_dv high after delimiter", rx_dv, 1);
        send_nib(4'h1); send_nib(4'h8); send_nib(4'hA); send_nib(4'hF); send_nib(4'h0);
        send_grp(G_T, 1'b0);
        chk(rx_dv == 1'b0, "R6 rx_dv low after T", rx_dv, 0);
        send_grp(G_R, 1'b0);
        send_grp(G_IDLE, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0);
        push_exp(4'h1, 0); push_exp(4'h8, 0); push_exp(4'hA, 0);
        push_exp(4'hF, 0); push_exp(4'h0, 0);
        compare("R5", 0);
    endtask

    // R2: delimiter at an offset of 3 bits
    task automatic t_offset();
        clear_cap();
        rx_bit_vld = 1'b1;
        rx_bit = 1'b0; @(negedge clk);
        rx_bit = 1'b1; @(negedge clk);
        rx_bit = 1'b0; @(negedge clk);
        rx_bit_vld = 1'b0;
        send_ssd();
        send_nib(4'h3); send_nib(4'hC); send_nib(4'h7);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0); send_grp(G_IDLE, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0);
        push_exp(4'h3, 0); push_exp(4'hC, 0); push_exp(4'h7, 0);
        compare("R2", 0);
    endtask

    // R3
    task automatic t_no_idle();
        clear_cap();
        send_grp(G_IDLE, 1'b0);
        send_nib(4'h4);
        send_grp(G_J, 1'b0);
        send_grp(G_K, 1'b0);
        chk(rx_dv == 1'b0, "R3 rx_dv stays low", rx_dv, 0);
        send_nib(4'h1); send_nib(4'h2);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0); send_grp(G_IDLE, 1'b0);
        compare("R3", 0);
    endtask

    // R7
    task automatic t_bad_code();
        clear_cap();
        send_ssd();
        send_nib(4'h2);
        send_grp(5'b00000, 1'b0);
        chk(rx_dv == 1'b1, "R7 rx_dv held on bad code", rx_dv, 1);
        send_nib(4'h9);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0);
        push_exp(4'h2, 0); push_exp(4'h0, 1); push_exp(4'h9, 0);
        compare("R7", 0);
    endtask

    // R8
    task automatic t_lone_r();
        clear_cap();
        send_ssd();
        send_nib(4'hB);
        send_grp(G_R, 1'b0);
        chk(rx_dv == 1'b1, "R8 rx_dv held over lone R", rx_dv, 1);
        send_nib(4'hD);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0);
        push_exp(4'hB, 0); push_exp(4'hD, 0);
        compare("R8", 0);
    endtask

    // R9
    task automatic t_idle_mid();
        clear_cap();
        send_ssd();
        send_nib(4'h3); send_nib(4'h4);
        send_grp(G_IDLE, 1'b0);
        chk(rx_dv == 1'b0, "R9 rx_dv low after idle", rx_dv, 0);
        send_nib(4'h5); send_nib(4'h6);
        send_ssd();
        send_nib(4'h7);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0); push_exp(4'h3, 0); push_exp(4'h4, 0);
        push_exp(4'h5, 0); push_exp(4'h5, 0); push_exp(4'h7, 0);
        compare("R9", 0);
    endtask

    // R10
    task automatic t_lock_drop();
        clear_cap();
        send_ssd();
        send_nib(4'h1);
        rx_bit = 1'b1; rx_bit_vld = 1'b1;
        @(negedge clk);
        rx_bit_vld = 1'b0;
        rx_lock = 1'b0;
        @(negedge clk);
        chk(rx_dv == 1'b0, "R10 rx_dv low after lock loss", rx_dv, 0);
        rx_lock = 1'b1;
        send_nib(4'h6); send_nib(4'h7);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0);
        send_ssd();
        send_nib(4'h2);
        send_grp(G_T, 1'b0); send_grp(G_R, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0); push_exp(4'h1, 0);
        push_exp(4'h5, 0); push_exp(4'h5, 0); push_exp(4'h2, 0);
        compare("R10", 0);
    endtask

    // R6: T followed by a non-R group
    task automatic t_t_no_r();
        clear_cap();
        send_ssd();
        send_nib(4'h9);
        send_grp(G_T, 1'b0);
        send_nib(4'h0);
        send_grp(G_IDLE, 1'b0);
        push_exp(4'h5, 0); push_exp(4'h5, 0); push_exp(4'h9, 0);
        compare("R6", 1);
    endtask

    // R11
    task automatic t_gaps();
        clear_cap();
        send_grp(G_IDLE, 1'b1);
        send_grp(G_J, 1'b1);
        send_grp(G_K, 1'b1);
        send_grp(enc(4'hE), 1'b1);
        send_grp(enc(4'h6), 1'b1);
        send_grp(G_T, 1'b1); send_grp(G_R, 1'b1);
        push_exp(4'h5, 0); push_exp(4'h5, 0); push_exp(4'hE, 0); push_exp(4'h6, 0);
        compare("R11", 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_offset();
        t_no_idle();
        t_bad_code();
        t_lone_r();
        t_idle_mid();
        t_lock_drop();
        t_t_no_r();
        t_gaps();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule